// File: doc/BRIEF.md
# Periodic Alarm Comparator

This block keeps four alarm bytes (seconds, minutes, hours and day of month, all in BCD) and checks them against the live time-of-day fields once per second. When the fields it is told to watch agree, it raises an interrupt for one clock cycle and sets a sticky alarm flag. Software reads that flag through a small byte register port, and the read clears it. The clock counter that produces the time fields and the seconds tick is outside this block.

Bit 7 of each alarm byte removes that field from the comparison. The masks build on each other from the largest field down: with no mask the alarm repeats monthly. Masking the day gives a daily alarm. Masking day and hours gives an hourly alarm. Masking day, hours and minutes gives an alarm once a minute. Any other pattern of mask bits fires on every tick. A write whose value is out of range for its field is dropped, so the stored alarm never holds an impossible time.

A small sequencer runs the check. It has three states:
- `ST_IDLE` waits for a tick. On a tick it captures the clock fields and moves to `ST_CHECK` (transition *tick seen*).
- `ST_CHECK` compares the alarm bytes with the captured fields. On a match it moves to `ST_FIRE` (transition *match*). Otherwise it returns to `ST_IDLE` (transition *no match*).
- `ST_FIRE` drives the interrupt for one cycle and always returns to `ST_IDLE` (transition *pulse done*).

Top module: `rtc_alarm_unit`

## Requirements
- R1: After reset, all four alarm bytes read 0x00, `alarm_irq` is 0 and `alarm_flag` is 0.
- R2: Register map, byte wide, addresses are offsets:
  - 0 is the flags byte. The alarm flag is at bit 6 and all other bits read 0.
  - 2, 3, 4 and 5 are alarm seconds, minutes, hours and date.
  - Any other offset reads 0x00.
  - `reg_rdata` is updated at the clock edge that samples `reg_rd`.
- R3: A write is accepted only if the BCD value (tens nibble × 10 + units nibble) is in range. Seconds and minutes use bits 6:0 and must be 0..59. Hours use bits 5:0 and must be 0..23. Date uses bits 4:0 and must not be 0. An accepted write stores the whole byte, including bit 7. A rejected write leaves the register unchanged.
- R4: With no mask bit set, the alarm fires when date, hours, minutes and seconds all match.
- R5: With only the date mask set, the alarm fires when hours, minutes and seconds match.
- R6: With only the date and hours masks set, the alarm fires when minutes and seconds match.
- R7: With only the date, hours and minutes masks set, the alarm fires when seconds match.
- R8: Any other combination of mask bits fires on every tick.
- R9: The comparison happens only for a tick accepted while idle, and it uses the field values sampled at that tick. If the tick is sampled at clock edge N, `alarm_irq` is high from edge N+1 to edge N+2 and low otherwise. Ticks must be at least three cycles apart.
- R10: A match sets `alarm_flag` at the same edge that raises `alarm_irq`. The flag stays set until the flags byte is read; that read returns bit 6 = 1 and clears the flag. If a match and a flags read happen in the same cycle, the match wins.
- R11: Writes to the flags byte have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| tod_sec | input | 8 | Current seconds, BCD |
| tod_min | input | 8 | Current minutes, BCD |
| tod_hour | input | 8 | Current hours, BCD |
| tod_date | input | 8 | Current day of month, BCD |
| sec_tick | input | 1 | One-cycle pulse per second |
| alarm_irq | output | 1 | One-cycle alarm interrupt |
| alarm_flag | output | 1 | Sticky alarm flag |

## Verification
The bench builds the block with its default parameters: a 3-bit offset, the flags byte at offset 0 and the alarm bytes starting at offset 2. This keeps the whole address space small enough to visit, including the unmapped offsets. Every one of the 256 byte values is written to each alarm register and read back against a range model. All 16 mask patterns are then run with the clock fields either fully matching or differing in exactly one field. The fields are also changed while a comparison is in progress, to show that the captured values are the ones used.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    localparam int NUM_FIELDS = 4;
    localparam int BYTE_W     = 8;

    // Field index order also fixes the address order (seconds lowest).
    typedef enum logic [1:0] {
        FLD_SEC  = 2'd0,
        FLD_MIN  = 2'd1,
        FLD_HOUR = 2'd2,
        FLD_DATE = 2'd3
    } field_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_FIRE  = 2'd2
    } seq_e;

    typedef enum logic [2:0] {
        RPT_MONTH = 3'd0,
        RPT_DAY   = 3'd1,
        RPT_HOUR  = 3'd2,
        RPT_MIN   = 3'd3,
        RPT_SEC   = 3'd4
    } repeat_e;

    // Bits of each alarm byte that carry the BCD value.
    function automatic logic [BYTE_W-1:0] field_bits(input int idx);
        case (idx)
            0, 1:    return 8'h7F;
            2:       return 8'h3F;
            default: return 8'h1F;
        endcase
    endfunction

    // Tens nibble times ten plus the units nibble.
    function automatic int bcd_to_bin(input logic [BYTE_W-1:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic field_ok(input int idx, input logic [BYTE_W-1:0] v);
        int val;
        val = bcd_to_bin(v & field_bits(idx));
        case (idx)
            0, 1:    return (val <= 59);
            2:       return (val <= 23);
            default: return (val != 0);
        endcase
    endfunction

endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
    import rtc_alarm_pkg::*;
#(
    parameter int ADDR_W     = 3,
    parameter int ALARM_BASE = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [ADDR_W-1:0]                    addr,
    input  logic [BYTE_W-1:0]                    wdata,
    output logic [NUM_FIELDS-1:0][BYTE_W-1:0]    alarm_q
);

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(ALARM_BASE + i);
        logic hit;
        logic ok;

        always_comb begin
            hit = wr_en && (addr == MY_ADDR);
            ok  = field_ok(i, wdata);
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                alarm_q[i] <= '0;
            end else if (hit && ok) begin
                alarm_q[i] <= wdata;
            end
        end
    end

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alarm_pkg::*;
(
    input  logic [NUM_FIELDS-1:0][BYTE_W-1:0] alarm_q,
    input  logic [NUM_FIELDS-1:0][BYTE_W-1:0] fields,
    output logic                              match
);

    logic [NUM_FIELDS-1:0] mask;
    logic [NUM_FIELDS-1:0] cmp_en;
    logic [NUM_FIELDS-1:0] eq;
    repeat_e               mode;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
        always_comb begin
            mask[i] = alarm_q[i][BYTE_W-1];
            eq[i]   = (((alarm_q[i] ^ fields[i]) & field_bits(i)) == '0);
        end
    end

    // Masks accumulate from date downward; anything else repeats each second.
    always_comb begin
        unique case (mask)
            4'b0000: mode = RPT_MONTH;
            4'b1000: mode = RPT_DAY;
            4'b1100: mode = RPT_HOUR;
            4'b1110: mode = RPT_MIN;
            default: mode = RPT_SEC;
        endcase
    end

    always_comb begin
        unique case (mode)
            RPT_MONTH: cmp_en = 4'b1111;
            RPT_DAY:   cmp_en = 4'b0111;
            RPT_HOUR:  cmp_en = 4'b0011;
            RPT_MIN:   cmp_en = 4'b0001;
            default:   cmp_en = 4'b0000;
        endcase
        match = &(eq | ~cmp_en);
    end

endmodule

// File: rtl/rtc_alarm_fsm.sv
module rtc_alarm_fsm
    import rtc_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic match,
    output logic snap_en,
    output logic set_flag,
    output logic irq
);

    seq_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (sec_tick) state_nx = ST_CHECK;
            ST_CHECK: state_nx = match ? ST_FIRE : ST_IDLE;
            ST_FIRE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        snap_en  = (state == ST_IDLE) && sec_tick;
        set_flag = (state == ST_CHECK) && match;
        irq      = (state == ST_FIRE);
    end

endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
    import rtc_alarm_pkg::*;
#(
    parameter int ADDR_W     = 3,
    parameter int FLAG_OFS   = 0,
    parameter int ALARM_BASE = 2,
    parameter int FLAG_BIT   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [7:0]        tod_sec,
    input  logic [7:0]        tod_min,
    input  logic [7:0]        tod_hour,
    input  logic [7:0]        tod_date,
    input  logic              sec_tick,
    output logic              alarm_irq,
    output logic              alarm_flag
);

    localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(FLAG_OFS);

    logic [NUM_FIELDS-1:0][BYTE_W-1:0] alarm_q;
    logic [NUM_FIELDS-1:0][BYTE_W-1:0] snap_q;
    logic                              match;
    logic                              snap_en;
    logic                              set_flag;
    logic                              flag_rd;
    logic [BYTE_W-1:0]                 rd_mux;

    rtc_alarm_regs #(
        .ADDR_W     (ADDR_W),
        .ALARM_BASE (ALARM_BASE)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .alarm_q (alarm_q)
    );

    // Capture the clock fields at the tick so later changes cannot race the compare.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (snap_en) begin
            snap_q <= {tod_date, tod_hour, tod_min, tod_sec};
        end
    end

    rtc_alarm_match match_i (
        .alarm_q (alarm_q),
        .fields  (snap_q),
        .match   (match)
    );

    rtc_alarm_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .match    (match),
        .snap_en  (snap_en),
        .set_flag (set_flag),
        .irq      (alarm_irq)
    );

    always_comb begin
        flag_rd = reg_rd && (reg_addr == FLAG_ADDR);
        rd_mux  = '0;
        if (reg_addr == FLAG_ADDR) begin
            rd_mux[FLAG_BIT] = alarm_flag;
        end
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (reg_addr == ADDR_W'(ALARM_BASE + i)) begin
                rd_mux = alarm_q[i];
            end
        end
    end

    // A match in the same cycle as a flags read keeps the flag set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_flag <= 1'b0;
        end else if (set_flag) begin
            alarm_flag <= 1'b1;
        end else if (flag_rd) begin
            alarm_flag <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/rtc_alarm_unit_chk.sv
module rtc_alarm_unit_chk
    import rtc_alarm_pkg::*;
#(
    parameter int ADDR_W     = 3,
    parameter int FLAG_OFS   = 0,
    parameter int ALARM_BASE = 2
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              reg_wr,
    input logic                              reg_rd,
    input logic [ADDR_W-1:0]                 reg_addr,
    input logic [7:0]                        reg_wdata,
    input logic                              sec_tick,
    input logic                              alarm_irq,
    input logic                              alarm_flag,
    input logic [NUM_FIELDS-1:0][BYTE_W-1:0] alarm_q
);

    localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(FLAG_OFS);

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |=> !alarm_irq); // R9

    AST_IRQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_irq) |-> $past(sec_tick, 2)); // R9

    AST_IRQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> alarm_flag); // R10

    AST_FLAG_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == FLAG_ADDR) |=> (!alarm_flag || alarm_irq)); // R10

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !(reg_rd && reg_addr == FLAG_ADDR)) |=> alarm_flag); // R10

    AST_FLAG_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == FLAG_ADDR && !alarm_flag) |=> (!alarm_flag || alarm_irq)); // R11

    AST_ALARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(alarm_q)); // R3

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_bad
        AST_BAD_WRITE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == ADDR_W'(ALARM_BASE + i) && !field_ok(i, reg_wdata))
            |=> $stable(alarm_q[i])); // R3
    end

endmodule

bind rtc_alarm_unit rtc_alarm_unit_chk #(
    .ADDR_W     (ADDR_W),
    .FLAG_OFS   (FLAG_OFS),
    .ALARM_BASE (ALARM_BASE)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .sec_tick   (sec_tick),
    .alarm_irq  (alarm_irq),
    .alarm_flag (alarm_flag),
    .alarm_q    (alarm_q)
);

// File: tb/rtc_alarm_unit_tb_top.sv
`timescale 1ns/1ps
module rtc_alarm_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_wr, reg_rd;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [7:0] tod_sec, tod_min, tod_hour, tod_date;
    logic       sec_tick, alarm_irq, alarm_flag;

    int errs   = 0;
    int checks = 0;

    always #2 clk = ~clk;

    rtc_alarm_unit dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tod_sec(tod_sec), .tod_min(tod_min), .tod_hour(tod_hour),
        .tod_date(tod_date), .sec_tick(sec_tick), .alarm_irq(alarm_irq),
        .alarm_flag(alarm_flag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(posedge clk); @(negedge clk);
        d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    function automatic int bcd(input int v);
        return (v / 16) * 10 + (v % 16);
    endfunction

    function automatic bit valid(input int f, input int v);
        int m;
        m = (f < 2) ? 8'h7F : (f == 2) ? 8'h3F : 8'h1F;
        if (f < 2)  return bcd(v & m) <= 59;
        if (f == 2) return bcd(v & m) <= 23;
        return bcd(v & m) != 0;
    endfunction

    initial begin
        #(4 * 150000);
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [7:0] model [4];
        logic [7:0] base  [4];
        logic [7:0] diff  [4];
        base = '{8'h30, 8'h45, 8'h17, 8'h12};
        diff = '{8'h31, 8'h44, 8'h16, 8'h13};

        rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
        tod_sec = 0; tod_min = 0; tod_hour = 0; tod_date = 0; sec_tick = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        check(alarm_irq == 0, "R1 irq", alarm_irq, 0);
        check(alarm_flag == 0, "R1 flag", alarm_flag, 0);
        for (int f = 0; f < 4; f++) begin
            rd(3'(2 + f), d);
            check(d == 0, "R1 alarm byte", d, 0);
            model[f] = 8'h00;
        end

        // R11 flags byte not writable
        wr(3'd0, 8'hFF);
        rd(3'd0, d);
        check(d == 0, "R11 flags write", d, 0);

        // R2 unmapped offsets
        for (int a = 1; a < 8; a++) begin
            if (a == 1 || a > 5) begin
                rd(3'(a), d);
                check(d == 0, "R2 unmapped", d, 0);
            end
        end

        // R3 full value sweep on every alarm byte
        for (int f = 0; f < 4; f++) begin
            for (int v = 0; v < 256; v++) begin
                wr(3'(2 + f), 8'(v));
                if (valid(f, v)) model[f] = 8'(v);
                rd(3'(2 + f), d);
                check(d == model[f], "R3 range filter", d, model[f]);
            end
        end

        // R4..R8, R9, R10 across all mask patterns and single-field mismatches
        for (int m = 0; m < 16; m++) begin
            for (int k = -1; k < 4; k++) begin
                logic [3:0] en;
                string      req;
                bit         exp;
                for (int f = 0; f < 4; f++) wr(3'(2 + f), base[f] | (m[f] ? 8'h80 : 8'h00));
                case (m)
                    0:  begin en = 4'b1111; req = "R4 monthly"; end
                    8:  begin en = 4'b0111; req = "R5 daily"; end
                    12: begin en = 4'b0011; req = "R6 hourly"; end
                    14: begin en = 4'b0001; req = "R7 per-minute"; end
                    default: begin en = 4'b0000; req = "R8 every tick"; end
                endcase
                exp = !(k >= 0 && en[k]);
                tod_sec  = (k == 0) ? diff[0] : base[0];
                tod_min  = (k == 1) ? diff[1] : base[1];
                tod_hour = (k == 2) ? diff[2] : base[2];
                tod_date = (k == 3) ? diff[3] : base[3];
                // R9 no tick, no compare
                repeat (2) @(negedge clk);
                check(alarm_irq == 0, "R9 no tick irq", alarm_irq, 0);
                check(alarm_flag == 0, "R9 no tick flag", alarm_flag, 0);
                sec_tick = 1'b1;
                @(posedge clk); @(negedge clk);
                sec_tick = 1'b0;
                // change fields mid-compare; sampled values must be used (R9)
                tod_sec = 8'h00; tod_min = 8'h00; tod_hour = 8'h00; tod_date = 8'h00;
                check(alarm_irq == 0, "R9 irq early", alarm_irq, 0);
                @(posedge clk); @(negedge clk);
                check(alarm_irq == exp, req, alarm_irq, exp);
                check(alarm_flag == exp, "R10 flag set", alarm_flag, exp);
                @(posedge clk); @(negedge clk);
                check(alarm_irq == 0, "R9 pulse width", alarm_irq, 0);
                rd(3'd0, d);
                check(d == (exp ? 8'h40 : 8'h00), "R10 flag read", d, exp ? 8'h40 : 8'h00);
                check(alarm_flag == 0, "R10 flag cleared", alarm_flag, 0);
            end
        end

        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule